// File: doc/BRIEF.md
# Block-Scaled Operand Descriptor Checker

This block takes a 16-byte operand descriptor that addresses a block-scaled matrix operand. It decodes the descriptor and validates it in a single registered stage. Each descriptor carries two co-located addresses: the packed element data, and the per-block scale values that go with it. Each descriptor also carries an element count and a scale base partition. A marker bit picks one of two layouts: a direct layout, and a shifted gather layout that adds an index address in front of the other fields.

A producer presents the descriptor together with its element type code and raises `in_valid`. One cycle later the block raises `out_valid` with the following results:

- the decoded addresses;
- the formed scale address;
- the logical element count, which is four times the stored count for packed types;
- the step direction;
- the scale partition;
- a pass flag and a reason code.

The reason code names the first check that failed. The block does not access memory, dequantise data or build descriptors.

Top module: `mxd_operand_check`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge, and all results for that descriptor are presented in the same cycle. When `in_valid` is low at an edge, `out_valid` is low after it. Reset clears `out_valid`, `pass_o` and `elem_count_o`.
- R2: The descriptor uses `desc_i[8k+7:8k]` as byte k. In the direct layout, bytes 0..3 hold the data address, bytes 4..7 the scale address field, bytes 8..9 the stored count, byte 10 the step byte and byte 11 the scale partition. All multi-byte fields are little-endian.
- R3: When bit 5 of byte 3 (`desc_i[29]`) is set, the indirect layout applies. Bytes 0..3 give the index address, which is output with bit 29 cleared. Bytes 4..7 give the data address, bytes 8..11 the scale address field, bytes 12..13 the stored count and byte 15 the partition. `indirect_o` is 1, no step check applies and `step_neg_o` is 0. In the direct layout, `indirect_o` and `index_addr_o` are 0.
- R4: Bytes 12..15 of the direct layout, and byte 14 of the indirect layout, have no effect on any output.
- R5: For element type codes 2, 8 and 9, `elem_count_o` is four times the stored count. For every other code it equals the stored count. The output is 18 bits wide.
- R6: A stored count of zero fails the descriptor with reason code 1.
- R7: In the direct layout the step byte must be 0x01 or 0xFF, meaning (byte+1) & 0xFD equals 0. Otherwise the descriptor fails with reason code 2. `step_neg_o` is 1 exactly when the step byte is 0xFF.
- R8: The scale partition must be a multiple of 4 and no greater than 15, so one of 0, 4, 8 or 12. Otherwise the descriptor fails with reason code 3.
- R9: When several checks fail, the reason code follows a fixed priority: count first, then step, then partition. `pass_o` is 1 with reason code 0 only when every check passes. `pass_o` is 0 with a nonzero code otherwise.
- R10: `scale_addr_o` equals the scale address field plus ((partition << 18) & 0xFF800000), taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor strobe |
| desc_i | input | 128 | Descriptor, byte k at bits 8k+7..8k |
| elem_type_i | input | 5 | Element type code |
| out_valid | output | 1 | Results valid |
| pass_o | output | 1 | Descriptor accepted |
| reason_o | output | 2 | 0 ok, 1 zero count, 2 bad step, 3 bad partition |
| indirect_o | output | 1 | Indirect layout decoded |
| index_addr_o | output | 32 | Gather index address (indirect only) |
| data_addr_o | output | 32 | Data address |
| scale_addr_o | output | 32 | Formed scale address |
| elem_count_o | output | 18 | Logical element count |
| step_neg_o | output | 1 | Step direction is negative |
| scale_part_o | output | 8 | Scale base partition byte |

## Verification
The hardest case to reach from the ports is a descriptor that passes every check. Uniform random bytes almost never give a legal step byte, an aligned partition of 15 or less and a nonzero count all at once. The stimulus therefore draws step bytes, partitions and counts from weighted pools, so that legal values dominate. It also biases the type code toward the packed types. Directed cases add several failures at once to test the priority order. They also send descriptor pairs that differ only in ignored bytes, and use the largest stored count with a packed type.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
   localparam int DESC_BYTES = 16;
   localparam int DESC_W     = DESC_BYTES * 8;
   localparam int ADDR_W     = 32;
   localparam int RAW_CNT_W  = 16;
   localparam int MARK_BIT   = 3 * 8 + 5;

   typedef enum logic [1:0] {
      RSN_OK    = 2'd0,
      RSN_COUNT = 2'd1,
      RSN_STEP  = 2'd2,
      RSN_PART  = 2'd3
   } mxd_reason_e;

   typedef struct packed {
      logic                 indirect;
      logic [ADDR_W-1:0]    idx_addr;
      logic [ADDR_W-1:0]    data_addr;
      logic [ADDR_W-1:0]    scale_field;
      logic [RAW_CNT_W-1:0] raw_count;
      logic [7:0]           step_byte;
      logic [7:0]           part_byte;
   } mxd_fields_t;

   function automatic logic is_packed_type(input logic [7:0] t);
      return (t == 8'd2) || (t == 8'd8) || (t == 8'd9);
   endfunction
endpackage

// File: rtl/mxd_direct_decode.sv
module mxd_direct_decode
   import mxd_pkg::*;
(
   input  logic [95:0]  lo_i,
   output mxd_fields_t  fields_o
);
   always_comb begin
      fields_o             = '0;
      fields_o.indirect    = 1'b0;
      fields_o.idx_addr    = '0;
      fields_o.data_addr   = lo_i[31:0];
      fields_o.scale_field = lo_i[63:32];
      fields_o.raw_count   = lo_i[79:64];
      fields_o.step_byte   = lo_i[87:80];
      fields_o.part_byte   = lo_i[95:88];
   end
endmodule

// File: rtl/mxd_indirect_decode.sv
module mxd_indirect_decode
   import mxd_pkg::*;
(
   input  logic [111:0] lo_i,
   input  logic [7:0]   part_byte_i,
   output mxd_fields_t  fields_o
);
   localparam logic [ADDR_W-1:0] MARK_CLR = ~(ADDR_W'(1) << MARK_BIT);

   always_comb begin
      fields_o             = '0;
      fields_o.indirect    = 1'b1;
      fields_o.idx_addr    = lo_i[31:0] & MARK_CLR;
      fields_o.data_addr   = lo_i[63:32];
      fields_o.scale_field = lo_i[95:64];
      fields_o.raw_count   = lo_i[111:96];
      fields_o.step_byte   = 8'h00;
      fields_o.part_byte   = part_byte_i;
   end
endmodule

// File: rtl/mxd_field_check.sv
module mxd_field_check
   import mxd_pkg::*;
#(
   parameter int PACK_LOG2  = 2,
   parameter int MAX_PART   = 15,
   parameter int ALIGN_BITS = 2,
   localparam int COUNT_W   = RAW_CNT_W + PACK_LOG2
)(
   input  mxd_fields_t        fields_i,
   input  logic [7:0]         elem_type_i,
   output logic               pass_o,
   output mxd_reason_e        reason_o,
   output logic [COUNT_W-1:0] count_o,
   output logic               step_neg_o
);
   logic [7:0] step_inc;
   logic       cnt_ok, step_ok, part_ok;

   assign step_inc = fields_i.step_byte + 8'd1;
   assign cnt_ok   = (fields_i.raw_count != '0);
   assign step_ok  = fields_i.indirect || ((step_inc & 8'hFD) == 8'h00);
   assign part_ok  = (fields_i.part_byte[ALIGN_BITS-1:0] == '0) &&
                     (fields_i.part_byte <= 8'(MAX_PART));

   assign step_neg_o = !fields_i.indirect && (fields_i.step_byte == 8'hFF);

   assign count_o = is_packed_type(elem_type_i) ?
                    {fields_i.raw_count, {PACK_LOG2{1'b0}}} :
                    COUNT_W'(fields_i.raw_count);

   always_comb begin
      if (!cnt_ok)       reason_o = RSN_COUNT;
      else if (!step_ok) reason_o = RSN_STEP;
      else if (!part_ok) reason_o = RSN_PART;
      else               reason_o = RSN_OK;
   end
   assign pass_o = (reason_o == RSN_OK);
endmodule

// File: rtl/mxd_operand_check.sv
module mxd_operand_check
   import mxd_pkg::*;
#(
   parameter int            TYPE_W           = 5,
   parameter int            PACK_LOG2        = 2,
   parameter int            MAX_PART         = 15,
   parameter int            ALIGN_BITS       = 2,
   parameter int            PART_SHIFT       = 18,
   parameter logic [31:0]   PART_MASK        = 32'hFF80_0000,
   parameter bit            SUPPORT_INDIRECT = 1'b1,
   localparam int           COUNT_W          = RAW_CNT_W + PACK_LOG2
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [DESC_W-1:0]   desc_i,
   input  logic [TYPE_W-1:0]   elem_type_i,
   output logic                out_valid,
   output logic                pass_o,
   output logic [1:0]          reason_o,
   output logic                indirect_o,
   output logic [ADDR_W-1:0]   index_addr_o,
   output logic [ADDR_W-1:0]   data_addr_o,
   output logic [ADDR_W-1:0]   scale_addr_o,
   output logic [COUNT_W-1:0]  elem_count_o,
   output logic                step_neg_o,
   output logic [7:0]          scale_part_o
);
   if (TYPE_W < 1 || TYPE_W > 8) begin : g_bad_type_w
      $error("TYPE_W must lie in 1..8");
   end
   if (PACK_LOG2 < 1 || PACK_LOG2 > 4) begin : g_bad_pack
      $error("PACK_LOG2 must lie in 1..4");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS > 7) begin : g_bad_align
      $error("ALIGN_BITS must lie in 1..7");
   end
   if (PART_SHIFT < 0 || PART_SHIFT > 24) begin : g_bad_shift
      $error("PART_SHIFT must lie in 0..24");
   end

   mxd_fields_t        dir_f, sel_f;
   logic               chk_pass, chk_neg;
   mxd_reason_e        chk_reason;
   logic [COUNT_W-1:0] chk_count;
   logic [ADDR_W-1:0]  part_term, scale_addr_c;

   mxd_direct_decode u_dir (
      .lo_i     (desc_i[95:0]),
      .fields_o (dir_f)
   );

   if (SUPPORT_INDIRECT) begin : g_ind
      mxd_fields_t ind_f;
      mxd_indirect_decode u_ind (
         .lo_i        (desc_i[111:0]),
         .part_byte_i (desc_i[127:120]),
         .fields_o    (ind_f)
      );
      assign sel_f = desc_i[MARK_BIT] ? ind_f : dir_f;
   end else begin : g_dir_only
      assign sel_f = dir_f;
   end

   mxd_field_check #(
      .PACK_LOG2  (PACK_LOG2),
      .MAX_PART   (MAX_PART),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_chk (
      .fields_i    (sel_f),
      .elem_type_i (8'(elem_type_i)),
      .pass_o      (chk_pass),
      .reason_o    (chk_reason),
      .count_o     (chk_count),
      .step_neg_o  (chk_neg)
   );

   assign part_term    = (ADDR_W'(sel_f.part_byte) << PART_SHIFT) & PART_MASK;
   assign scale_addr_c = sel_f.scale_field + part_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         pass_o       <= 1'b0;
         reason_o     <= 2'd0;
         indirect_o   <= 1'b0;
         index_addr_o <= '0;
         data_addr_o  <= '0;
         scale_addr_o <= '0;
         elem_count_o <= '0;
         step_neg_o   <= 1'b0;
         scale_part_o <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            pass_o       <= chk_pass;
            reason_o     <= chk_reason;
            indirect_o   <= sel_f.indirect;
            index_addr_o <= sel_f.idx_addr;
            data_addr_o  <= sel_f.data_addr;
            scale_addr_o <= scale_addr_c;
            elem_count_o <= chk_count;
            step_neg_o   <= chk_neg;
            scale_part_o <= sel_f.part_byte;
         end
      end
   end
endmodule

// File: rtl/mxd_operand_check_sva.sv
module mxd_operand_check_sva #(
   parameter int COUNT_W = 18
)(
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               out_valid,
   input logic               pass_o,
   input logic [1:0]         reason_o,
   input logic               indirect_o,
   input logic [COUNT_W-1:0] elem_count_o,
   input logic               step_neg_o,
   input logic [7:0]         scale_part_o,
   input logic [31:0]        data_addr_o
);
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(data_addr_o));
   assert_pass_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && pass_o |-> reason_o == 2'd0);
   assert_fail_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !pass_o |-> reason_o != 2'd0);
   assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && pass_o |-> elem_count_o != '0);
   assert_part_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && pass_o |-> (scale_part_o[1:0] == 2'b00) && (scale_part_o <= 8'd15));
   assert_gather_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && indirect_o |-> !step_neg_o && reason_o != 2'd2);
endmodule

bind mxd_operand_check mxd_operand_check_sva #(.COUNT_W(COUNT_W)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .pass_o       (pass_o),
   .reason_o     (reason_o),
   .indirect_o   (indirect_o),
   .elem_count_o (elem_count_o),
   .step_neg_o   (step_neg_o),
   .scale_part_o (scale_part_o),
   .data_addr_o  (data_addr_o)
);

// File: tb/sim_mxd_operand_check.sv
`timescale 1ns/1ps
module sim_mxd_operand_check;
   typedef struct packed {
      logic        pass;
      logic [1:0]  reason;
      logic        ind;
      logic [31:0] idx;
      logic [31:0] data;
      logic [31:0] scale;
      logic [17:0] count;
      logic        neg;
      logic [7:0]  part;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] desc = '0;
   logic [4:0]   etype = '0;
   logic         out_valid, pass_o, indirect_o, step_neg_o;
   logic [1:0]   reason_o;
   logic [31:0]  index_addr_o, data_addr_o, scale_addr_o;
   logic [17:0]  elem_count_o;
   logic [7:0]   scale_part_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   exp_t exp_q;
   bit   pend_valid = 0;

   always #2.5 clk = ~clk;

   mxd_operand_check u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .desc_i(desc),
      .elem_type_i(etype), .out_valid(out_valid), .pass_o(pass_o),
      .reason_o(reason_o), .indirect_o(indirect_o), .index_addr_o(index_addr_o),
      .data_addr_o(data_addr_o), .scale_addr_o(scale_addr_o),
      .elem_count_o(elem_count_o), .step_neg_o(step_neg_o),
      .scale_part_o(scale_part_o)
   );

   function automatic exp_t model(input logic [127:0] d, input logic [4:0] t);
      exp_t e;
      logic [15:0] cnt;
      logic [7:0]  step;
      logic [31:0] sf;
      logic        step_ok, part_ok;
      e = '0;
      e.ind = d[29];
      if (e.ind) begin
         e.idx  = d[31:0] & 32'hDFFF_FFFF;
         e.data = d[63:32];
         sf     = d[95:64];
         cnt    = d[111:96];
         e.part = d[127:120];
         step   = 8'h00;
      end else begin
         e.idx  = 32'h0;
         e.data = d[31:0];
         sf     = d[63:32];
         cnt    = d[79:64];
         step   = d[87:80];
         e.part = d[95:88];
      end
      e.count = (t == 5'd2 || t == 5'd8 || t == 5'd9) ? {cnt, 2'b00} : {2'b00, cnt};
      step_ok = e.ind || step == 8'h01 || step == 8'hFF;
      e.neg   = !e.ind && step == 8'hFF;
      part_ok = (e.part == 8'd0) || (e.part == 8'd4) || (e.part == 8'd8) || (e.part == 8'd12);
      if (cnt == 16'h0)  e.reason = 2'd1;
      else if (!step_ok) e.reason = 2'd2;
      else if (!part_ok) e.reason = 2'd3;
      else               e.reason = 2'd0;
      e.pass  = (e.reason == 2'd0);
      e.scale = sf + (({24'h0, e.part} << 18) & 32'hFF80_0000);
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic check_outputs();
      if (!pend_valid) begin
         chk(out_valid == 1'b0, "R1 idle out_valid", 64'(out_valid), 64'h0);
         return;
      end
      chk(out_valid == 1'b1, "R1 out_valid", 64'(out_valid), 64'h1);
      chk(pass_o == exp_q.pass && reason_o == exp_q.reason, "R9/R6/R7/R8 pass,reason",
          {pass_o, reason_o}, {exp_q.pass, exp_q.reason});
      chk(indirect_o == exp_q.ind && index_addr_o == exp_q.idx, "R3 layout,index",
          {indirect_o, index_addr_o}, {exp_q.ind, exp_q.idx});
      chk(data_addr_o == exp_q.data, "R2 data addr", 64'(data_addr_o), 64'(exp_q.data));
      chk(scale_addr_o == exp_q.scale, "R10 scale addr", 64'(scale_addr_o), 64'(exp_q.scale));
      chk(elem_count_o == exp_q.count, "R5 count", 64'(elem_count_o), 64'(exp_q.count));
      chk(step_neg_o == exp_q.neg, "R7 step dir", 64'(step_neg_o), 64'(exp_q.neg));
      chk(scale_part_o == exp_q.part, "R8 partition", 64'(scale_part_o), 64'(exp_q.part));
   endtask

   task automatic step_cycle(input bit v, input logic [127:0] d, input logic [4:0] t);
      @(negedge clk);
      check_outputs();
      in_valid = v;
      desc     = d;
      etype    = t;
      if (v) exp_q = model(d, t);
      pend_valid = v;
   endtask

   function automatic logic [127:0] rand_desc(input bit ind);
      logic [127:0] d;
      int s, p;
      d = {$urandom, $urandom, $urandom, $urandom};
      d[29] = ind;
      s = $urandom % 5;
      p = $urandom % 4;
      if (!ind) begin
         d[87:80] = (s < 2) ? 8'h01 : (s < 4) ? 8'hFF : 8'($urandom);
         if (p != 3) d[95:88] = 8'(4 * ($urandom % 4));
         if ($urandom % 8 == 0) d[79:64] = 16'h0;
      end else begin
         if (p != 3) d[127:120] = 8'(4 * ($urandom % 4));
         if ($urandom % 8 == 0) d[111:96] = 16'h0;
      end
      return d;
   endfunction

   function automatic logic [4:0] rand_type();
      int r;
      r = $urandom % 6;
      if (r == 0) return 5'd2;
      if (r == 1) return 5'd8;
      if (r == 2) return 5'd9;
      return 5'($urandom % 20);
   endfunction

   initial begin : watchdog
      #(5ns * 100000);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [127:0] base, alt;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && pass_o == 1'b0 && elem_count_o == '0, "R1 reset state",
          {out_valid, pass_o, 14'h0, elem_count_o}, 64'h0);
      rst_n = 1'b1;

      // R6/R7/R9: zero count with bad step and bad partition -> count wins
      base = '0; base[79:64] = 16'h0; base[87:80] = 8'h33; base[95:88] = 8'h07;
      step_cycle(1, base, 5'd1);
      // R7/R9: bad step and bad partition -> step wins
      base[79:64] = 16'h0010;
      step_cycle(1, base, 5'd1);
      // R8: only partition bad
      base[87:80] = 8'hFF;
      step_cycle(1, base, 5'd1);
      // R8 boundary: partition 16 rejected, 12 accepted
      base[95:88] = 8'd16;
      step_cycle(1, base, 5'd1);
      base[95:88] = 8'd12;
      step_cycle(1, base, 5'd1);
      // R5: maximum count with each packed type and an unpacked one
      base[79:64] = 16'hFFFF;
      step_cycle(1, base, 5'd2);
      step_cycle(1, base, 5'd8);
      step_cycle(1, base, 5'd9);
      step_cycle(1, base, 5'd10);
      // R1: idle cycle between descriptors
      step_cycle(0, '0, 5'd0);
      // R4: direct pair differing only in bytes 12..15
      base = rand_desc(0); base[87:80] = 8'h01; base[95:88] = 8'd8; base[79:64] = 16'h0042;
      alt = base; alt[127:96] = ~base[127:96];
      step_cycle(1, base, 5'd3);
      step_cycle(1, alt, 5'd3);
      // R4/R3: gather pair differing only in byte 14
      base = rand_desc(1); base[127:120] = 8'd4; base[111:96] = 16'h0001;
      alt = base; alt[119:112] = ~base[119:112];
      step_cycle(1, base, 5'd8);
      step_cycle(1, alt, 5'd8);
      // R10: invalid partition reaching masked address bits
      base = rand_desc(0); base[95:88] = 8'hFF;
      step_cycle(1, base, 5'd0);

      for (int i = 0; i < 3000; i++) begin
         if ($urandom % 10 == 0) step_cycle(0, '0, 5'd0);
         else step_cycle(1, rand_desc(1'($urandom % 2)), rand_type());
      end
      step_cycle(0, '0, 5'd0);
      step_cycle(0, '0, 5'd0);

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule